// File: doc/BRIEF.md
# Received Message Collector

The collector sits on the consumer side of a byte-serial message stream. Each message arrives as a burst: a strobe held high for a number of consecutive cycles, a 5-bit type code and one byte per strobed cycle. The block rebuilds every burst into one parallel record. The record holds the type, the 16-bit requester ID, the 16-bit vendor ID, a 32-bit payload with a flag for whether the payload is present, and the snoop and no-snoop latencies. The record is published together with a one-cycle completion pulse.

A burst ends at the first cycle in which the strobe is low. The block then compares the number of strobed cycles with the length that the type requires. A burst with the wrong length, with a type code that changed partway through, or with an unused type code raises a one-cycle error pulse in place of the completion pulse. The published record is left unchanged in that case. The block also keeps a level bit for each of the four legacy interrupt lines. Well-formed set and clear messages update these bits.

Top module: `msg_collector`

## Requirements
- R1: While reset is high and in the cycle after it falls, every output is zero: both pulses, all record fields and all four interrupt levels.
- R2: The first strobed byte of a burst becomes requester ID bits [15:8] and the second becomes bits [7:0]. If the burst is well formed, `rec_done` goes high for exactly one cycle. It rises at the clock edge that samples the first low strobe after the burst, and the record outputs carry the new values in that same cycle. A gap of a single low-strobe cycle between bursts is enough.
- R3: Type codes 0 to 14 and code 18 complete after exactly 2 strobed cycles. For these codes the vendor ID, payload, latencies and `rec_has_data` are zero.
- R4: Code 15 completes after exactly 6 strobed cycles. Bytes 3 to 6 form the payload, least significant byte first.
- R5: Code 16 completes after exactly 6 strobed cycles. Bytes 3 and 4 form the snoop latency and bytes 5 and 6 form the no-snoop latency, each least significant byte first.
- R6: Codes 19 and 20 complete after 4 or 8 strobed cycles. Bytes 3 and 4 form the vendor ID, low byte first. An 8-cycle burst places bytes 5 to 8 in the payload, low byte first, and sets `rec_has_data` to 1. A 4-cycle burst gives a zero payload and `rec_has_data` = 0.
- R7: A burst whose length does not match its type causes `rec_len_err` to pulse for one cycle, at the same point where `rec_done` would have pulsed. This includes bursts longer than 8 cycles. `rec_done` stays low and all record outputs keep their previous values.
- R8: A burst in which the type code differs from the type of its first cycle in any later strobed cycle is treated as an error, as in R7.
- R9: Codes 17 and 21 to 31 are always treated as errors, whatever the burst length.
- R10: `intx_level[k]`, for k = 0 to 3, is set by a well-formed code 3+2k and cleared by a well-formed code 4+2k. It changes in the same cycle as `rec_done`. Bursts with errors and all other codes leave it unchanged.
- R11: Record outputs and interrupt levels change only in a cycle in which `rec_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| msg_vld | input | 1 | Burst strobe; high for each byte of a message |
| msg_type | input | 5 | Message type code, valid when the strobe is high |
| msg_byte | input | 8 | Message byte, valid when the strobe is high |
| rec_done | output | 1 | One-cycle pulse: a well-formed message is published |
| rec_len_err | output | 1 | One-cycle pulse: the burst was malformed |
| rec_type | output | 5 | Type of the published message |
| rec_req_id | output | 16 | Requester ID (bus number in the upper byte) |
| rec_vendor_id | output | 16 | Vendor ID of vendor-defined messages |
| rec_payload | output | 32 | Payload of slot-power and vendor-defined messages |
| rec_has_data | output | 1 | A vendor-defined message carried a payload |
| rec_snoop_lat | output | 16 | Snoop latency of a latency report |
| rec_nosnoop_lat | output | 16 | No-snoop latency of a latency report |
| intx_level | output | 4 | Levels of the four legacy interrupt lines |

## Verification
The bench uses the default parameters: 8-bit bytes, a beat counter sized for 8-beat bursts, and four interrupt lines. With these values, a 10-beat burst drives the beat counter into saturation, and set/clear sequences exercise all four level bits. Every length class is covered at its legal length and at one illegal length, together with mid-burst type changes and single-cycle gaps between bursts.

// File: rtl/msgc_pkg.sv
package msgc_pkg;

  localparam int TYPE_W = 5;

  localparam int LEN_SHORT    = 2;
  localparam int LEN_SIX      = 6;
  localparam int LEN_VDM_BARE = 4;
  localparam int LEN_VDM_FULL = 8;

  localparam logic [TYPE_W-1:0] T_SHORT_LAST = 5'd14;
  localparam logic [TYPE_W-1:0] T_SLOT_PWR   = 5'd15;
  localparam logic [TYPE_W-1:0] T_LAT_REP    = 5'd16;
  localparam logic [TYPE_W-1:0] T_UNLOCK     = 5'd18;
  localparam logic [TYPE_W-1:0] T_VDM0       = 5'd19;
  localparam logic [TYPE_W-1:0] T_VDM1       = 5'd20;
  localparam int                T_INTX_FIRST = 3;

  typedef enum logic [2:0] {
    CL_SHORT,
    CL_PAY6,
    CL_LAT6,
    CL_VEND,
    CL_BAD
  } msg_class_e;

  function automatic msg_class_e classify(input logic [TYPE_W-1:0] t);
    if (t <= T_SHORT_LAST || t == T_UNLOCK) return CL_SHORT;
    if (t == T_SLOT_PWR)                   return CL_PAY6;
    if (t == T_LAT_REP)                    return CL_LAT6;
    if (t == T_VDM0 || t == T_VDM1)        return CL_VEND;
    return CL_BAD;
  endfunction

endpackage

// File: rtl/msgc_beat_track.sv
module msgc_beat_track
  import msgc_pkg::*;
#(
  parameter int MAX_BEATS = 8,
  localparam int CNT_W = $clog2(MAX_BEATS + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld,
  input  logic [TYPE_W-1:0] typ,
  output logic              first_beat,
  output logic [CNT_W-1:0]  beat_idx,
  output logic [TYPE_W-1:0] burst_type,
  output logic [CNT_W-1:0]  beat_cnt,
  output logic              mixed,
  output logic              burst_end
);

  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_BEATS + 1);

  logic              in_burst;
  logic [CNT_W-1:0]  cnt;
  logic [TYPE_W-1:0] typ0;
  logic              mix_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_burst <= 1'b0;
      cnt      <= '0;
      typ0     <= '0;
      mix_q    <= 1'b0;
    end else if (vld) begin
      if (!in_burst) begin
        in_burst <= 1'b1;
        cnt      <= CNT_W'(1);
        typ0     <= typ;
        mix_q    <= 1'b0;
      end else begin
        if (cnt != CNT_SAT) cnt <= cnt + CNT_W'(1);
        mix_q <= mix_q | (typ != typ0);
      end
    end else begin
      in_burst <= 1'b0;
      cnt      <= '0;
      mix_q    <= 1'b0;
    end
  end

  assign first_beat = vld & ~in_burst;
  assign beat_idx   = in_burst ? cnt : '0;
  assign burst_type = typ0;
  assign beat_cnt   = cnt;
  assign mixed      = mix_q;
  assign burst_end  = in_burst & ~vld;

endmodule

// File: rtl/msgc_field_asm.sv
module msgc_field_asm
  import msgc_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 4,
  localparam int ID_W  = 2 * BYTE_W,
  localparam int PAY_W = 4 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld,
  input  logic              first_beat,
  input  logic [CNT_W-1:0]  beat_idx,
  input  logic [TYPE_W-1:0] burst_type,
  input  logic [BYTE_W-1:0] data,
  output logic [ID_W-1:0]   req_id,
  output logic [ID_W-1:0]   vendor_id,
  output logic [PAY_W-1:0]  payload,
  output logic [ID_W-1:0]   snoop_lat,
  output logic [ID_W-1:0]   nosnoop_lat
);

  msg_class_e cls;
  assign cls = classify(burst_type);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_id      <= '0;
      vendor_id   <= '0;
      payload     <= '0;
      snoop_lat   <= '0;
      nosnoop_lat <= '0;
    end else if (vld) begin
      if (first_beat) begin
        req_id      <= {data, {BYTE_W{1'b0}}};
        vendor_id   <= '0;
        payload     <= '0;
        snoop_lat   <= '0;
        nosnoop_lat <= '0;
      end else begin
        if (beat_idx == CNT_W'(1)) req_id[BYTE_W-1:0] <= data;
        case (cls)
          CL_PAY6: begin
            for (int k = 0; k < 4; k++)
              if (beat_idx == CNT_W'(2 + k)) payload[k*BYTE_W +: BYTE_W] <= data;
          end
          CL_LAT6: begin
            for (int k = 0; k < 2; k++) begin
              if (beat_idx == CNT_W'(2 + k)) snoop_lat[k*BYTE_W +: BYTE_W]   <= data;
              if (beat_idx == CNT_W'(4 + k)) nosnoop_lat[k*BYTE_W +: BYTE_W] <= data;
            end
          end
          CL_VEND: begin
            for (int k = 0; k < 2; k++)
              if (beat_idx == CNT_W'(2 + k)) vendor_id[k*BYTE_W +: BYTE_W] <= data;
            for (int k = 0; k < 4; k++)
              if (beat_idx == CNT_W'(4 + k)) payload[k*BYTE_W +: BYTE_W] <= data;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/msgc_len_check.sv
module msgc_len_check
  import msgc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic [TYPE_W-1:0] burst_type,
  input  logic [CNT_W-1:0]  beat_cnt,
  input  logic              mixed,
  output logic              good,
  output logic              has_data
);

  msg_class_e cls;
  logic       len_ok;

  always_comb begin
    cls = classify(burst_type);
    case (cls)
      CL_SHORT:         len_ok = (beat_cnt == CNT_W'(LEN_SHORT));
      CL_PAY6, CL_LAT6: len_ok = (beat_cnt == CNT_W'(LEN_SIX));
      CL_VEND:          len_ok = (beat_cnt == CNT_W'(LEN_VDM_BARE)) ||
                                 (beat_cnt == CNT_W'(LEN_VDM_FULL));
      default:          len_ok = 1'b0;
    endcase
    good     = len_ok & ~mixed;
    has_data = (cls == CL_VEND) && (beat_cnt == CNT_W'(LEN_VDM_FULL));
  end

endmodule

// File: rtl/msgc_intx_levels.sv
module msgc_intx_levels
  import msgc_pkg::*;
#(
  parameter int NUM_INTX = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                upd,
  input  logic [TYPE_W-1:0]   typ,
  output logic [NUM_INTX-1:0] level
);

  for (genvar g = 0; g < NUM_INTX; g++) begin : g_line
    localparam logic [TYPE_W-1:0] SET_CODE = TYPE_W'(T_INTX_FIRST + 2 * g);
    localparam logic [TYPE_W-1:0] CLR_CODE = TYPE_W'(T_INTX_FIRST + 2 * g + 1);
    always_ff @(posedge clk) begin
      if (rst)                         level[g] <= 1'b0;
      else if (upd && typ == SET_CODE) level[g] <= 1'b1;
      else if (upd && typ == CLR_CODE) level[g] <= 1'b0;
    end
  end

  assert_intx_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(level));

endmodule

// File: rtl/msg_collector.sv
module msg_collector
  import msgc_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int MAX_BEATS = 8,
  parameter int NUM_INTX  = 4,
  localparam int CNT_W = $clog2(MAX_BEATS + 2),
  localparam int ID_W  = 2 * BYTE_W,
  localparam int PAY_W = 4 * BYTE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                msg_vld,
  input  logic [TYPE_W-1:0]   msg_type,
  input  logic [BYTE_W-1:0]   msg_byte,
  output logic                rec_done,
  output logic                rec_len_err,
  output logic [TYPE_W-1:0]   rec_type,
  output logic [ID_W-1:0]     rec_req_id,
  output logic [ID_W-1:0]     rec_vendor_id,
  output logic [PAY_W-1:0]    rec_payload,
  output logic                rec_has_data,
  output logic [ID_W-1:0]     rec_snoop_lat,
  output logic [ID_W-1:0]     rec_nosnoop_lat,
  output logic [NUM_INTX-1:0] intx_level
);

  logic              first_beat, mixed, burst_end, good, has_data;
  logic [CNT_W-1:0]  beat_idx, beat_cnt;
  logic [TYPE_W-1:0] burst_type;
  logic [ID_W-1:0]   h_req, h_vend, h_snp, h_nsnp;
  logic [PAY_W-1:0]  h_pay;

  msgc_beat_track #(.MAX_BEATS(MAX_BEATS)) u_track (
    .clk(clk), .rst(rst), .vld(msg_vld), .typ(msg_type),
    .first_beat(first_beat), .beat_idx(beat_idx), .burst_type(burst_type),
    .beat_cnt(beat_cnt), .mixed(mixed), .burst_end(burst_end)
  );

  msgc_field_asm #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_asm (
    .clk(clk), .rst(rst), .vld(msg_vld), .first_beat(first_beat),
    .beat_idx(beat_idx), .burst_type(burst_type), .data(msg_byte),
    .req_id(h_req), .vendor_id(h_vend), .payload(h_pay),
    .snoop_lat(h_snp), .nosnoop_lat(h_nsnp)
  );

  msgc_len_check #(.CNT_W(CNT_W)) u_chk (
    .burst_type(burst_type), .beat_cnt(beat_cnt), .mixed(mixed),
    .good(good), .has_data(has_data)
  );

  msgc_intx_levels #(.NUM_INTX(NUM_INTX)) u_intx (
    .clk(clk), .rst(rst), .upd(burst_end & good), .typ(burst_type),
    .level(intx_level)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_done        <= 1'b0;
      rec_len_err     <= 1'b0;
      rec_type        <= '0;
      rec_req_id      <= '0;
      rec_vendor_id   <= '0;
      rec_payload     <= '0;
      rec_has_data    <= 1'b0;
      rec_snoop_lat   <= '0;
      rec_nosnoop_lat <= '0;
    end else begin
      rec_done    <= burst_end & good;
      rec_len_err <= burst_end & ~good;
      if (burst_end && good) begin
        rec_type        <= burst_type;
        rec_req_id      <= h_req;
        rec_vendor_id   <= h_vend;
        rec_payload     <= h_pay;
        rec_has_data    <= has_data;
        rec_snoop_lat   <= h_snp;
        rec_nosnoop_lat <= h_nsnp;
      end
    end
  end

  assert_done_err_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(rec_done && rec_len_err));

  assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
    rec_done |=> !rec_done);

  assert_done_after_gap_R2: assert property (@(posedge clk) disable iff (rst)
    rec_done |-> !$past(msg_vld));

  assert_err_after_gap_R8: assert property (@(posedge clk) disable iff (rst)
    rec_len_err |-> !$past(msg_vld));

  assert_rec_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !rec_done |-> $stable({rec_type, rec_req_id, rec_vendor_id, rec_payload,
                           rec_has_data, rec_snoop_lat, rec_nosnoop_lat}));

endmodule

// File: tb/tb_msg_collector.sv
module tb_msg_collector;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        msg_vld = 1'b0;
  logic [4:0]  msg_type = '0;
  logic [7:0]  msg_byte = '0;
  logic        rec_done, rec_len_err, rec_has_data;
  logic [4:0]  rec_type;
  logic [15:0] rec_req_id, rec_vendor_id, rec_snoop_lat, rec_nosnoop_lat;
  logic [31:0] rec_payload;
  logic [3:0]  intx_level;

  always #4 clk = ~clk;

  msg_collector dut (
    .clk(clk), .rst(rst), .msg_vld(msg_vld), .msg_type(msg_type),
    .msg_byte(msg_byte), .rec_done(rec_done), .rec_len_err(rec_len_err),
    .rec_type(rec_type), .rec_req_id(rec_req_id), .rec_vendor_id(rec_vendor_id),
    .rec_payload(rec_payload), .rec_has_data(rec_has_data),
    .rec_snoop_lat(rec_snoop_lat), .rec_nosnoop_lat(rec_nosnoop_lat),
    .intx_level(intx_level)
  );

  typedef struct {
    bit          err;
    logic [4:0]  typ;
    logic [15:0] rid, vid, snp, nsnp;
    logic [31:0] pay;
    bit          hd;
    logic [3:0]  lv;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t mdl;
  int   total = 0;
  int   bad   = 0;
  bit   done_flag = 1'b0;

  // 2 = two-beat, 6 = payload six-beat, 7 = latency six-beat, 8 = vendor, 0 = unused
  function automatic int cls_of(input logic [4:0] t);
    if (t <= 5'd14 || t == 5'd18) return 2;
    if (t == 5'd15) return 6;
    if (t == 5'd16) return 7;
    if (t == 5'd19 || t == 5'd20) return 8;
    return 0;
  endfunction

  task automatic send(input logic [4:0] t, input int n, input logic [7:0] b[8],
                      input int chg, input int gap, input string tag);
    exp_t e;
    int   cl;
    bit   ok;
    cl = cls_of(t);
    ok = (chg < 0) && ((cl == 2 && n == 2) || ((cl == 6 || cl == 7) && n == 6) ||
                       (cl == 8 && (n == 4 || n == 8)));
    if (ok) begin
      mdl.typ = t; mdl.rid = {b[0], b[1]};
      mdl.vid = '0; mdl.pay = '0; mdl.snp = '0; mdl.nsnp = '0; mdl.hd = 1'b0;
      case (cl)
        6: mdl.pay = {b[5], b[4], b[3], b[2]};
        7: begin mdl.snp = {b[3], b[2]}; mdl.nsnp = {b[5], b[4]}; end
        8: begin
          mdl.vid = {b[3], b[2]};
          if (n == 8) begin mdl.pay = {b[7], b[6], b[5], b[4]}; mdl.hd = 1'b1; end
        end
        default: ;
      endcase
      if (t >= 5'd3 && t <= 5'd10) mdl.lv[(int'(t) - 3) / 2] = t[0];
    end
    e = mdl; e.err = !ok; e.tag = tag;
    q.push_back(e);
    for (int i = 0; i < n; i++) begin
      msg_vld  = 1'b1;
      msg_type = (i == chg) ? (t ^ 5'd1) : t;
      msg_byte = b[i % 8];
      @(negedge clk);
    end
    msg_vld = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && (rec_done || rec_len_err)) begin
      total++;
      if (q.size() == 0) begin
        bad++;
        $display("FAIL R2 unexpected event: done=%0b err=%0b expected none", rec_done, rec_len_err);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (rec_done !== !e.err || rec_len_err !== e.err || rec_type !== e.typ ||
            rec_req_id !== e.rid || rec_vendor_id !== e.vid || rec_payload !== e.pay ||
            rec_has_data !== e.hd || rec_snoop_lat !== e.snp ||
            rec_nosnoop_lat !== e.nsnp || intx_level !== e.lv) begin
          bad++;
          $display("FAIL %s actual done=%0b err=%0b typ=%0d rid=%h vid=%h pay=%h hd=%0b snp=%h nsnp=%h lv=%b expected done=%0b err=%0b typ=%0d rid=%h vid=%h pay=%h hd=%0b snp=%h nsnp=%h lv=%b",
                   e.tag, rec_done, rec_len_err, rec_type, rec_req_id, rec_vendor_id,
                   rec_payload, rec_has_data, rec_snoop_lat, rec_nosnoop_lat, intx_level,
                   !e.err, e.err, e.typ, e.rid, e.vid, e.pay, e.hd, e.snp, e.nsnp, e.lv);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    mdl = '{err: 1'b0, typ: '0, rid: '0, vid: '0, snp: '0, nsnp: '0, pay: '0,
            hd: 1'b0, lv: '0, tag: ""};
    repeat (3) @(negedge clk);
    total++;
    if (rec_done || rec_len_err || rec_type || rec_req_id || rec_vendor_id ||
        rec_payload || rec_has_data || rec_snoop_lat || rec_nosnoop_lat || intx_level) begin
      bad++; $display("FAIL R1 during reset actual nonzero outputs expected all zero");
    end
    rst = 1'b0;
    @(negedge clk);
    total++;
    if (rec_done || rec_len_err || rec_req_id || rec_payload || intx_level) begin
      bad++; $display("FAIL R1 after reset actual nonzero outputs expected all zero");
    end

    send(5'd0,  2, '{8'h12, 8'h34, 0, 0, 0, 0, 0, 0}, -1, 2, "R2 R3 two-beat code 0");
    send(5'd14, 2, '{8'hA1, 8'hB2, 0, 0, 0, 0, 0, 0}, -1, 1, "R2 R3 code 14 single gap");
    send(5'd18, 2, '{8'h5C, 8'hD3, 0, 0, 0, 0, 0, 0}, -1, 1, "R3 code 18");
    send(5'd15, 6, '{8'h01, 8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 0, 0}, -1, 2, "R4 six-beat payload");
    send(5'd16, 6, '{8'h0A, 8'h0B, 8'hC1, 8'hC2, 8'hD1, 8'hD2, 0, 0}, -1, 1, "R5 latencies");
    send(5'd19, 4, '{8'h33, 8'h44, 8'hEF, 8'hBE, 0, 0, 0, 0}, -1, 2, "R6 vendor no data");
    send(5'd20, 8, '{8'h55, 8'h66, 8'h34, 8'h12, 8'hA0, 8'hB0, 8'hC0, 8'hD0}, -1, 1, "R6 vendor with data");
    send(5'd3,  2, '{8'h70, 8'h71, 0, 0, 0, 0, 0, 0}, -1, 1, "R10 set line 0");
    send(5'd7,  2, '{8'h72, 8'h73, 0, 0, 0, 0, 0, 0}, -1, 1, "R10 set line 2");
    send(5'd9,  2, '{8'h74, 8'h75, 0, 0, 0, 0, 0, 0}, -1, 1, "R10 set line 3");
    send(5'd4,  2, '{8'h76, 8'h77, 0, 0, 0, 0, 0, 0}, -1, 2, "R10 clear line 0");
    send(5'd5,  3, '{8'h78, 8'h79, 8'h7A, 0, 0, 0, 0, 0}, -1, 2, "R7 R10 set with bad length ignored");
    send(5'd0,  3, '{8'h90, 8'h91, 8'h92, 0, 0, 0, 0, 0}, -1, 2, "R7 short code three beats");
    send(5'd15, 2, '{8'h93, 8'h94, 0, 0, 0, 0, 0, 0}, -1, 2, "R7 six-beat code two beats");
    send(5'd19, 6, '{8'h95, 8'h96, 8'h97, 8'h98, 8'h99, 8'h9A, 0, 0}, -1, 2, "R7 vendor six beats");
    send(5'd20, 10, '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08}, -1, 2, "R7 ten-beat overlong");
    send(5'd15, 6, '{8'hE1, 8'hE2, 8'hE3, 8'hE4, 8'hE5, 8'hE6, 0, 0}, 2, 2, "R8 type change mid burst");
    send(5'd10, 2, '{8'hE7, 8'hE8, 0, 0, 0, 0, 0, 0}, 1, 2, "R8 R10 clear with type change ignored");
    send(5'd17, 2, '{8'hF1, 8'hF2, 0, 0, 0, 0, 0, 0}, -1, 2, "R9 code 17");
    send(5'd25, 4, '{8'hF3, 8'hF4, 8'hF5, 8'hF6, 0, 0, 0, 0}, -1, 2, "R9 code 25");
    send(5'd10, 2, '{8'h80, 8'h81, 0, 0, 0, 0, 0, 0}, -1, 1, "R10 R11 clear line 3");
    send(5'd6,  2, '{8'h82, 8'h83, 0, 0, 0, 0, 0, 0}, -1, 1, "R10 clear idle line 1");

    repeat (4) @(negedge clk);
    total++;
    if (q.size() != 0) begin
      bad++; $display("FAIL R2 missing events actual=%0d pending expected=0", q.size());
    end
    done_flag = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule